// File: doc/BRIEF.md
# Floppy Controller Bus Interface

This block sits between a processor that talks to peripherals through I/O instructions and up to two floppy drive subsystems that exchange words over a single serial line. Each accepted instruction carries a device field, a drive select bit and a three-bit operation field. The block recognises five operations: load-command, transfer-data, and three conditional skips that test the transfer-request, error and done flags. A load-command latches the drive function, the word width and the maintenance setting from the accumulator. It then strobes RUN toward the selected drive and shifts the command word out serially, MSB first.

A 16-bit shift register built from two 8-bit halves carries every word. A fill-buffer function produces one output word per transfer-data instruction. An empty-buffer function shifts words in from the drive and hands each one to the processor on the next transfer-data instruction. A wide mode moves 12-bit words, 64 to a sector. A narrow mode moves 8-bit bytes, 128 to a sector. A maintenance setting stops all drive traffic and turns transfer-data into a register loopback, so the processor can test the interface with no drive attached.

Top module: `fdc_bus_bridge`

## Requirements
- R1: After reset, RUN strobes, skip, read-valid, both shift-activity outputs and the read word are all zero.
- R2: An instruction is accepted only when iot_op[11:9]=110, iot_op[8:5]=DEV_CODE (default 0111) and iot_op[3]=0. The operation field iot_op[2:0] decodes as 1 load-command, 2 transfer-data, 3 skip-on-TR, 4 skip-on-error, 5 skip-on-done. Any other instruction has no effect.
- R3: A load-command with acc_in[7]=0 clears TR, DONE and ERROR. It pulses RUN for one cycle in the next cycle, latches acc_in[3:1] as the drive function and acc_in[6] as the mode (0 gives 12 bits, 1 gives 8 bits). It then shifts the low 12 or 8 bits of acc_in out on ser_out, MSB first, one bit per cycle, with shout_act high.
- R4: A load-command with acc_in[7]=1 enters maintenance. There is no RUN, no serial activity and no flag change. Each transfer-data in this state returns the register's previous word (masked to the mode width) on rd_data and loads acc_in.
- R5: For drive function 000 (fill), TR sets when the command finishes shifting. A transfer-data then clears TR, pulses RUN and shifts the accumulator word out.
- R6: For drive function 001 (empty), a word of the mode width is shifted in from ser_in, MSB first, right after the command, and TR then sets. A transfer-data presents that word on rd_data with a one-cycle rd_valid, clears TR, and starts the next word with a RUN pulse.
- R7: DONE sets after transfer 64 in wide mode or transfer 128 in narrow mode. TR does not set again, and the last transfer-data of an empty sequence gives no RUN pulse.
- R8: Any other drive function sets DONE as soon as the command word has shifted out.
- R9: skip_o is high in the cycle after a skip instruction exactly when the flag it tests was set.
- R10: A transfer-data outside maintenance while TR is clear gives no RUN, no read and no serial activity.
- R11: A high drv_err sets ERROR, and the next non-maintenance load-command clears it.
- R12: iot_op[4] steers every RUN pulse: 0 to run0_o, 1 to run1_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| iot_valid | input | 1 | I/O instruction present this cycle |
| iot_op | input | 12 | Instruction word |
| acc_in | input | 12 | Accumulator contents |
| drv_err | input | 1 | Error indication from drive |
| ser_in | input | 1 | Serial data from drive |
| ser_out | output | 1 | Serial data to drive |
| shout_act | output | 1 | ser_out carries a valid bit |
| shin_act | output | 1 | ser_in is being sampled |
| run0_o | output | 1 | RUN strobe, drive 0 |
| run1_o | output | 1 | RUN strobe, drive 1 |
| skip_o | output | 1 | Skip condition met |
| rd_data | output | 12 | Word for the accumulator |
| rd_valid | output | 1 | rd_data is new this cycle |

## Verification
RUN, rd_valid and skip_o each appear in the cycle that follows the edge that accepts the instruction. The bench samples them on the falling edge right after its driving task returns. Serial bit k of a word is on ser_out k cycles after the loading edge, and TR sets one full word time (12 or 8 cycles) later. The bench waits one word time plus one cycle before it issues skips or transfers. Serial and read words are matched against expected-word queues by monitors that sample only while the activity strobes are high.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
   localparam int OP_W = 12;
   // instruction fields
   localparam int OP_FN_HI   = 2;
   localparam int OP_DRIVE   = 4;
   localparam int OP_DEV_LO  = 5;
   localparam int OP_DEV_W   = 4;
   localparam logic [2:0] IO_OPCODE = 3'b110;
   // operation codes
   localparam logic [2:0] FN_LOAD_CMD  = 3'd1;
   localparam logic [2:0] FN_XFER      = 3'd2;
   localparam logic [2:0] FN_SKIP_TR   = 3'd3;
   localparam logic [2:0] FN_SKIP_ERR  = 3'd4;
   localparam logic [2:0] FN_SKIP_DONE = 3'd5;
   // accumulator fields of a command word
   localparam int ACC_MAINT = 7;
   localparam int ACC_MODE  = 6;
   localparam int ACC_FN_HI = 3;
   localparam int ACC_FN_LO = 1;
   // drive functions handled by the sequencer
   localparam logic [2:0] DF_FILL  = 3'b000;
   localparam logic [2:0] DF_EMPTY = 3'b001;

   typedef struct packed {
      logic lcd;
      logic xdr;
      logic skip_tr;
      logic skip_err;
      logic skip_done;
      logic drive;
   } iot_cmd_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SHOUT, ST_SHIN, ST_WAIT_OUT, ST_WAIT_IN
   } seq_st_e;
endpackage

// File: rtl/fdc_decode.sv
module fdc_decode
   import fdc_pkg::*;
#(
   parameter logic [OP_DEV_W-1:0] DEV_CODE = 4'b0111
) (
   input  logic            iot_valid,
   input  logic [OP_W-1:0] iot_op,
   output iot_cmd_t        cmd
);
   logic hit;
   logic [2:0] fn;

   assign fn  = iot_op[OP_FN_HI:0];
   assign hit = iot_valid
             && (iot_op[OP_W-1:OP_W-3] == IO_OPCODE)
             && (iot_op[OP_DEV_LO +: OP_DEV_W] == DEV_CODE)
             && !iot_op[3];

   always_comb begin
      cmd           = '0;
      cmd.drive     = iot_op[OP_DRIVE];
      cmd.lcd       = hit && (fn == FN_LOAD_CMD);
      cmd.xdr       = hit && (fn == FN_XFER);
      cmd.skip_tr   = hit && (fn == FN_SKIP_TR);
      cmd.skip_err  = hit && (fn == FN_SKIP_ERR);
      cmd.skip_done = hit && (fn == FN_SKIP_DONE);
   end
endmodule

// File: rtl/fdc_shreg.sv
module fdc_shreg #(
   parameter int HALF_W   = 8,
   parameter int HALVES   = 2,
   parameter int W_WIDE   = 12,
   parameter int W_NARROW = 8,
   localparam int REG_W   = HALF_W * HALVES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [REG_W-1:0] load_val,
   input  logic             shift,
   input  logic             sin,
   input  logic             wide,
   output logic             sout,
   output logic [REG_W-1:0] q
);
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [HALF_W-1:0] half_q;
      logic              cin;
      if (h == 0) begin : g_first
         assign cin = sin;
      end else begin : g_chain
         assign cin = q[h*HALF_W-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      half_q <= '0;
         else if (load)   half_q <= load_val[h*HALF_W +: HALF_W];
         else if (shift)  half_q <= {half_q[HALF_W-2:0], cin};
      end
      assign q[h*HALF_W +: HALF_W] = half_q;
   end

   assign sout = wide ? q[W_WIDE-1] : q[W_NARROW-1];

   // R6: a shift takes the serial input into the lowest bit
   assert_serial_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> (q[0] == $past(sin)));
endmodule

// File: rtl/fdc_seq.sv
module fdc_seq
   import fdc_pkg::*;
#(
   parameter int W_WIDE       = 12,
   parameter int W_NARROW     = 8,
   parameter int WORDS_WIDE   = 64,
   parameter int WORDS_NARROW = 128,
   parameter int REG_W        = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  iot_cmd_t         cmd,
   input  logic [OP_W-1:0]  acc,
   input  logic             drv_err,
   input  logic [REG_W-1:0] sr_q,
   output logic             sr_load,
   output logic [REG_W-1:0] sr_load_val,
   output logic             sr_shift,
   output logic             sr_wide,
   output logic             shout_act,
   output logic             shin_act,
   output logic             run0,
   output logic             run1,
   output logic             tr,
   output logic             err,
   output logic             done,
   output logic [OP_W-1:0]  rd_data,
   output logic             rd_valid
);
   localparam int MAXN = (WORDS_WIDE > WORDS_NARROW) ? WORDS_WIDE : WORDS_NARROW;
   localparam int XW   = $clog2(MAXN);
   localparam int BW   = $clog2(W_WIDE);
   localparam logic [REG_W-1:0] MASK_WIDE   = {{(REG_W-W_WIDE){1'b0}},   {W_WIDE{1'b1}}};
   localparam logic [REG_W-1:0] MASK_NARROW = {{(REG_W-W_NARROW){1'b0}}, {W_NARROW{1'b1}}};

   seq_st_e        st;
   logic [BW-1:0]  bitcnt;
   logic [XW-1:0]  xcnt;
   logic [2:0]     func;
   logic           wide, maint, cmd_ph;

   logic busy, lcd_ok, lcd_run, xdr_out, xdr_in, xdr_lb;
   logic bit_last, xfer_last, load_wide;
   logic [XW-1:0]  last_x;
   logic [OP_W-1:0] word_now;

   assign busy     = (st == ST_SHOUT) || (st == ST_SHIN);
   assign lcd_ok   = cmd.lcd && !busy;
   assign lcd_run  = lcd_ok && !acc[ACC_MAINT];
   assign xdr_out  = cmd.xdr && !maint && (st == ST_WAIT_OUT);
   assign xdr_in   = cmd.xdr && !maint && (st == ST_WAIT_IN);
   assign xdr_lb   = cmd.xdr && maint;

   assign last_x    = wide ? XW'(WORDS_WIDE - 1) : XW'(WORDS_NARROW - 1);
   assign xfer_last = (xcnt == last_x);
   assign bit_last  = (bitcnt == (wide ? BW'(W_WIDE - 1) : BW'(W_NARROW - 1)));

   assign load_wide   = lcd_ok ? !acc[ACC_MODE] : wide;
   assign sr_load     = lcd_ok || xdr_out || xdr_lb;
   assign sr_load_val = REG_W'(acc) & (load_wide ? MASK_WIDE : MASK_NARROW);
   assign sr_shift    = busy;
   assign sr_wide     = wide;
   assign shout_act   = (st == ST_SHOUT);
   assign shin_act    = (st == ST_SHIN);
   assign word_now    = OP_W'(sr_q & (wide ? MASK_WIDE : MASK_NARROW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bitcnt   <= '0;
         xcnt     <= '0;
         func     <= '0;
         wide     <= 1'b1;
         maint    <= 1'b0;
         cmd_ph   <= 1'b0;
         tr       <= 1'b0;
         err      <= 1'b0;
         done     <= 1'b0;
         run0     <= 1'b0;
         run1     <= 1'b0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         run0     <= 1'b0;
         run1     <= 1'b0;
         rd_valid <= 1'b0;
         err      <= drv_err || (err && !lcd_run);
         if (lcd_ok) begin
            maint <= acc[ACC_MAINT];
            wide  <= !acc[ACC_MODE];
            if (acc[ACC_MAINT]) begin
               st <= ST_IDLE;
            end else begin
               func   <= acc[ACC_FN_HI:ACC_FN_LO];
               tr     <= 1'b0;
               done   <= 1'b0;
               xcnt   <= '0;
               bitcnt <= '0;
               cmd_ph <= 1'b1;
               st     <= ST_SHOUT;
               run0   <= !cmd.drive;
               run1   <= cmd.drive;
            end
         end else if (xdr_lb) begin
            rd_data  <= word_now;
            rd_valid <= 1'b1;
         end else if (xdr_out) begin
            tr     <= 1'b0;
            bitcnt <= '0;
            st     <= ST_SHOUT;
            run0   <= !cmd.drive;
            run1   <= cmd.drive;
         end else if (xdr_in) begin
            tr       <= 1'b0;
            rd_data  <= word_now;
            rd_valid <= 1'b1;
            if (xfer_last) begin
               done <= 1'b1;
               st   <= ST_IDLE;
            end else begin
               xcnt   <= xcnt + 1'b1;
               bitcnt <= '0;
               st     <= ST_SHIN;
               run0   <= !cmd.drive;
               run1   <= cmd.drive;
            end
         end else begin
            unique case (st)
               ST_SHOUT: begin
                  bitcnt <= bitcnt + 1'b1;
                  if (bit_last) begin
                     bitcnt <= '0;
                     if (cmd_ph) begin
                        cmd_ph <= 1'b0;
                        if (func == DF_FILL) begin
                           tr <= 1'b1;
                           st <= ST_WAIT_OUT;
                        end else if (func == DF_EMPTY) begin
                           st <= ST_SHIN;
                        end else begin
                           done <= 1'b1;
                           st   <= ST_IDLE;
                        end
                     end else if (xfer_last) begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                     end else begin
                        xcnt <= xcnt + 1'b1;
                        tr   <= 1'b1;
                        st   <= ST_WAIT_OUT;
                     end
                  end
               end
               ST_SHIN: begin
                  bitcnt <= bitcnt + 1'b1;
                  if (bit_last) begin
                     bitcnt <= '0;
                     tr     <= 1'b1;
                     st     <= ST_WAIT_IN;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R3: a RUN pulse always follows an accepted command or transfer instruction
   assert_run_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run0 || run1) |-> $past(cmd.lcd || cmd.xdr));
   // R4: maintenance keeps the drive side quiet
   assert_maint_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      maint |-> !(run0 || run1 || shout_act || shin_act));
   // R7: request and completion never coexist
   assert_tr_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(tr && done));
   // R7: transfer count stays inside the sector
   assert_xcnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xcnt <= last_x);
   // R12: drive 1 strobe only for an instruction that selected drive 1
   assert_drive_steer_R12: assert property (@(posedge clk) disable iff (!rst_n)
      run1 |-> $past(cmd.drive));
endmodule

// File: rtl/fdc_bus_bridge.sv
module fdc_bus_bridge
   import fdc_pkg::*;
#(
   parameter logic [3:0] DEV_CODE = 4'b0111,
   parameter int W_WIDE       = 12,
   parameter int W_NARROW     = 8,
   parameter int WORDS_WIDE   = 64,
   parameter int WORDS_NARROW = 128,
   parameter int HALF_W       = 8,
   parameter int HALVES       = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        iot_valid,
   input  logic [11:0] iot_op,
   input  logic [11:0] acc_in,
   input  logic        drv_err,
   input  logic        ser_in,
   output logic        ser_out,
   output logic        shout_act,
   output logic        shin_act,
   output logic        run0_o,
   output logic        run1_o,
   output logic        skip_o,
   output logic [11:0] rd_data,
   output logic        rd_valid
);
   localparam int REG_W = HALF_W * HALVES;

   initial begin
      assert (W_WIDE <= REG_W && W_WIDE <= OP_W)
         else $error("wide word does not fit the register");
      assert (W_NARROW >= 2 && W_NARROW < W_WIDE)
         else $error("narrow word must be shorter than wide word");
      assert (HALF_W >= 2 && WORDS_WIDE >= 2 && WORDS_NARROW >= 2)
         else $error("degenerate sizing");
   end

   iot_cmd_t         cmd;
   logic             sr_load, sr_shift, sr_wide;
   logic [REG_W-1:0] sr_load_val, sr_q;
   logic             tr, err, done;

   fdc_decode #(.DEV_CODE(DEV_CODE)) u_dec (
      .iot_valid (iot_valid),
      .iot_op    (iot_op),
      .cmd       (cmd)
   );

   fdc_shreg #(
      .HALF_W(HALF_W), .HALVES(HALVES), .W_WIDE(W_WIDE), .W_NARROW(W_NARROW)
   ) u_sr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sr_load),
      .load_val (sr_load_val),
      .shift    (sr_shift),
      .sin      (ser_in),
      .wide     (sr_wide),
      .sout     (ser_out),
      .q        (sr_q)
   );

   fdc_seq #(
      .W_WIDE(W_WIDE), .W_NARROW(W_NARROW), .WORDS_WIDE(WORDS_WIDE),
      .WORDS_NARROW(WORDS_NARROW), .REG_W(REG_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd         (cmd),
      .acc         (acc_in),
      .drv_err     (drv_err),
      .sr_q        (sr_q),
      .sr_load     (sr_load),
      .sr_load_val (sr_load_val),
      .sr_shift    (sr_shift),
      .sr_wide     (sr_wide),
      .shout_act   (shout_act),
      .shin_act    (shin_act),
      .run0        (run0_o),
      .run1        (run1_o),
      .tr          (tr),
      .err         (err),
      .done        (done),
      .rd_data     (rd_data),
      .rd_valid    (rd_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) skip_o <= 1'b0;
      else        skip_o <= (cmd.skip_tr && tr) || (cmd.skip_err && err)
                         || (cmd.skip_done && done);
   end

   // R9: skip only follows an instruction cycle
   assert_skip_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> $past(iot_valid));
endmodule

// File: tb/fdc_bus_bridge_tb_top.sv
`timescale 1ns/1ps
module fdc_bus_bridge_tb_top;
   localparam logic [3:0] DEV = 4'b0111;
   localparam logic [2:0] F_LCD = 3'd1, F_XDR = 3'd2, F_STR = 3'd3, F_SER = 3'd4, F_SDN = 3'd5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iot_valid = 1'b0;
   logic [11:0] iot_op = '0, acc_in = '0;
   logic drv_err = 1'b0, ser_in = 1'b0;
   logic ser_out, shout_act, shin_act, run0_o, run1_o, skip_o, rd_valid;
   logic [11:0] rd_data;

   always #10 clk = ~clk;

   fdc_bus_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_op(iot_op),
      .acc_in(acc_in), .drv_err(drv_err), .ser_in(ser_in), .ser_out(ser_out),
      .shout_act(shout_act), .shin_act(shin_act), .run0_o(run0_o),
      .run1_o(run1_o), .skip_o(skip_o), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   int checks = 0, errors = 0;
   bit finished = 1'b0;
   logic [11:0] so_exp_q[$], rd_exp_q[$], src_q[$];
   int mon_w = 12, src_w = 8;

   task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic iot(input logic [3:0] dev, input logic drv, input logic [2:0] fn,
                      input logic [11:0] acc);
      iot_valid = 1'b1;
      iot_op    = {3'b110, dev, drv, 1'b0, fn};
      acc_in    = acc;
      @(negedge clk);
      iot_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic skipchk(input logic [2:0] fn, input logic exp, input string tag);
      iot(DEV, 1'b0, fn, 12'h000);
      chk(tag, {11'd0, skip_o}, {11'd0, exp});
   endtask

   // monitor: serial output words against the expected queue
   initial begin
      logic [11:0] sh_word;
      int sh_cnt;
      sh_word = '0;
      sh_cnt = 0;
      forever begin
         @(negedge clk);
         if (shout_act) begin
            sh_word = {sh_word[10:0], ser_out};
            sh_cnt++;
            if (sh_cnt == mon_w) begin
               sh_cnt = 0;
               if (so_exp_q.size() == 0) chk("R5 unexpected serial word", sh_word, 12'hFFF);
               else chk("R3/R5 serial word", sh_word & 12'((1 << mon_w) - 1), so_exp_q.pop_front());
            end
         end
      end
   end

   // monitor: words handed to the processor
   initial begin
      forever begin
         @(negedge clk);
         if (rd_valid) begin
            if (rd_exp_q.size() == 0) chk("R6 unexpected read word", rd_data, 12'hFFF);
            else chk("R6/R4 read word", rd_data, rd_exp_q.pop_front());
         end
      end
   end

   // drive model: supplies serial input bits MSB first
   initial begin
      logic [11:0] cur;
      int idx;
      cur = '0;
      idx = 0;
      forever begin
         @(negedge clk);
         if (shin_act) begin
            if (idx == 0) cur = (src_q.size() != 0) ? src_q.pop_front() : 12'h000;
            ser_in = cur[src_w - 1 - idx];
            idx++;
            if (idx == src_w) idx = 0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 run0", {11'd0, run0_o}, 12'd0);
      chk("R1 run1", {11'd0, run1_o}, 12'd0);
      chk("R1 skip", {11'd0, skip_o}, 12'd0);
      chk("R1 shout", {11'd0, shout_act}, 12'd0);
      chk("R1 shin", {11'd0, shin_act}, 12'd0);
      chk("R1 rd_valid", {11'd0, rd_valid}, 12'd0);
      chk("R1 rd_data", rd_data, 12'd0);

      // R2 another device code is ignored
      iot(4'b0011, 1'b0, F_LCD, 12'h000);
      chk("R2 foreign run0", {11'd0, run0_o}, 12'd0);
      chk("R2 foreign shout", {11'd0, shout_act}, 12'd0);

      // R3/R5 fill, wide mode, drive 0
      mon_w = 12;
      so_exp_q.push_back(12'h901);
      iot(DEV, 1'b0, F_LCD, 12'h901);
      chk("R3 run0 on command", {11'd0, run0_o}, 12'd1);
      chk("R12 run1 quiet", {11'd0, run1_o}, 12'd0);
      chk("R3 shout active", {11'd0, shout_act}, 12'd1);
      idle(13);
      skipchk(F_STR, 1'b1, "R5 TR after command");
      skipchk(F_SDN, 1'b0, "R9 no done yet");
      for (int i = 0; i < 64; i++) begin
         logic [11:0] w;
         w = 12'(i * 37 + 12'h5A1);
         so_exp_q.push_back(w);
         iot(DEV, 1'b0, F_XDR, w);
         chk("R5 run0 per word", {11'd0, run0_o}, 12'd1);
         idle(13);
         if (i < 63) skipchk(F_STR, 1'b1, "R5 TR per word");
      end
      skipchk(F_SDN, 1'b1, "R7 done after 64");
      skipchk(F_STR, 1'b0, "R7 no TR after last");

      // R10 transfer with no request
      iot(DEV, 1'b0, F_XDR, 12'hFFF);
      chk("R10 no run", {11'd0, run0_o}, 12'd0);
      chk("R10 no read", {11'd0, rd_valid}, 12'd0);
      chk("R10 no shift", {11'd0, shout_act}, 12'd0);
      idle(3);
      chk("R10 still idle", {11'd0, shout_act}, 12'd0);

      // R6/R7 empty, narrow mode, drive 1
      mon_w = 8;
      src_w = 8;
      so_exp_q.push_back(12'h042);
      for (int i = 0; i < 128; i++) begin
         logic [11:0] s;
         s = {4'd0, 8'(i * 29 + 7)};
         src_q.push_back(s);
         rd_exp_q.push_back(s);
      end
      iot(DEV, 1'b1, F_LCD, 12'hE42);
      chk("R12 run1 on command", {11'd0, run1_o}, 12'd1);
      chk("R12 run0 quiet", {11'd0, run0_o}, 12'd0);
      idle(17);
      for (int i = 0; i < 128; i++) begin
         iot(DEV, 1'b1, F_XDR, 12'h000);
         chk("R6 read valid", {11'd0, rd_valid}, 12'd1);
         if (i < 127) begin
            chk("R6 run1 per word", {11'd0, run1_o}, 12'd1);
            idle(9);
         end else begin
            chk("R7 no run after last", {11'd0, run1_o}, 12'd0);
         end
      end
      skipchk(F_SDN, 1'b1, "R7 done after 128");

      // R8 other function completes after the command
      mon_w = 12;
      so_exp_q.push_back(12'h304);
      iot(DEV, 1'b0, F_LCD, 12'h304);
      skipchk(F_SDN, 1'b0, "R8 done cleared by command");
      idle(12);
      skipchk(F_SDN, 1'b1, "R8 done after command");

      // R11 error flag
      drv_err = 1'b1;
      idle(1);
      drv_err = 1'b0;
      skipchk(F_SER, 1'b1, "R11 error set");
      so_exp_q.push_back(12'h304);
      iot(DEV, 1'b0, F_LCD, 12'h304);
      skipchk(F_SER, 1'b0, "R11 error cleared");
      idle(13);

      // R4 maintenance loopback
      drv_err = 1'b1;
      idle(1);
      drv_err = 1'b0;
      iot(DEV, 1'b0, F_LCD, 12'hA85);
      chk("R4 no run", {11'd0, run0_o | run1_o}, 12'd0);
      chk("R4 no shift", {11'd0, shout_act | shin_act}, 12'd0);
      skipchk(F_SER, 1'b1, "R4 error kept");
      skipchk(F_SDN, 1'b1, "R4 done kept");
      rd_exp_q.push_back(12'hA85);
      iot(DEV, 1'b0, F_XDR, 12'h5A3);
      chk("R4 loopback valid", {11'd0, rd_valid}, 12'd1);
      chk("R4 loopback no run", {11'd0, run0_o}, 12'd0);
      rd_exp_q.push_back(12'h5A3);
      iot(DEV, 1'b0, F_XDR, 12'h123);
      idle(5);

      chk("R5 serial queue drained", 12'(so_exp_q.size()), 12'd0);
      chk("R6 read queue drained", 12'(rd_exp_q.size()), 12'd0);
      chk("R6 source queue drained", 12'(src_q.size()), 12'd0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule